// File: doc/BRIEF.md
# Bus Command Handshake Synchronizer

This block carries command cycles from an asynchronous instrument bus into the clock domain of a local CPU. Every bus-side input (command strobe, read select, command match and the S2 timing strobe) first passes through a multi-stage synchronizer. The rising edge of the synchronized command strobe decides whether the command is taken. When nothing is waiting, the command is latched as pending and Q is returned. When a command is already waiting, the new one is refused: Q stays low and a busy indication is shown.

An accepted command raises the CPU interrupt on the falling edge of S2. The interrupt and the pending flag stay set until the CPU pulses its write-data-enable strobe. This keeps a second command out until the CPU has finished with the first.

A read is answered from a word that the CPU latched in advance. A CPU latch pulse sets a data-ready flag. A read that finds the flag set and the match input true returns Q together with read-valid and read-enable. The word is consumed when that command ends. A read that finds the flag set but the match input false returns nothing and discards the word after a set number of cycles.

Top module: `bus_cmd_sync`

## Requirements
- R1: Out of reset, q_resp, rd_valid, rd_en, cpu_irq and cmd_busy are all 0 and no read word is held. A reset that arrives while a command is pending clears the interrupt.
- R2: A command (rd_sel=0) that arrives with nothing pending is accepted. q_resp goes to 1 and stays there for as long as cmd_stb is held high.
- R3: cpu_irq is set by the falling edge of s2_stb that follows an accepted command, and not earlier.
- R4: Once set, cpu_irq and the pending state hold until cpu_wde is pulsed. They are clear one cycle after that pulse.
- R5: A command that arrives while another is pending is refused. q_resp stays 0, cmd_busy is 1 while its strobe is high, and cpu_irq is unaffected.
- R6: A read (rd_sel=1) with a word ready and cmd_match=1 drives q_resp, rd_valid and rd_en to 1. The word is consumed, so the next read finds nothing.
- R7: A read with no word ready keeps q_resp, rd_valid and rd_en at 0. It is still accepted as a pending command and raises cpu_irq.
- R8: A read with a word ready but cmd_match=0 keeps all three outputs at 0. The word is discarded MISS_DLY cycles after the strobe edge is seen, so a later matching read finds nothing.
- R9: A one-cycle cpu_latch pulse makes a word ready for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | Asynchronous general command strobe |
| rd_sel | input | 1 | Asynchronous flag marking the command as a read |
| cmd_match | input | 1 | Asynchronous flag: the latched word belongs to this read |
| s2_stb | input | 1 | Asynchronous bus timing strobe S2 |
| cpu_wde | input | 1 | CPU write-data-enable pulse that clears the request |
| cpu_latch | input | 1 | CPU pulse marking a read word as latched |
| q_resp | output | 1 | Q response to the bus |
| rd_valid | output | 1 | Read data valid |
| rd_en | output | 1 | Read data drive enable |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cmd_busy | output | 1 | A refused command is on the bus |

## Verification
A bus-side edge reaches the outputs three clock edges after it is first sampled: two synchronizer stages, then the edge-detect register that updates the response flags. The interrupt therefore follows the fall of S2 by the same three edges. A cpu_wde or cpu_latch pulse takes effect at the next edge. The bench drives on falling edges and holds each strobe for five cycles before it samples, which is well past the three-edge latency. It reads the interrupt one cycle after a CPU pulse. The mismatch discard is checked by waiting more than MISS_DLY cycles and then issuing a matching read, which must return nothing.

// File: rtl/bus_cmd_sync.sv
module bus_cmd_sync #(
  parameter int SYNC_LEN = 2,
  parameter int MISS_DLY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_stb,
  input  logic rd_sel,
  input  logic cmd_match,
  input  logic s2_stb,
  input  logic cpu_wde,
  input  logic cpu_latch,
  output logic q_resp,
  output logic rd_valid,
  output logic rd_en,
  output logic cpu_irq,
  output logic cmd_busy
);
  localparam int CW = $clog2(MISS_DLY + 1);

  logic [SYNC_LEN-1:0][3:0] sq;
  logic cmd_s, rd_s, mt_s, s2_s, cmd_p, s2_p;
  logic cmd_rise, cmd_fall, s2_fall;
  logic pend, rdy;
  logic [CW-1:0] miss_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sq    <= '0;
      cmd_p <= 1'b0;
      s2_p  <= 1'b0;
    end else begin
      sq[0] <= {cmd_stb, rd_sel, cmd_match, s2_stb};
      for (int i = 1; i < SYNC_LEN; i++) sq[i] <= sq[i-1];
      cmd_p <= cmd_s;
      s2_p  <= s2_s;
    end

  assign {cmd_s, rd_s, mt_s, s2_s} = sq[SYNC_LEN-1];
  assign cmd_rise = cmd_s & ~cmd_p;
  assign cmd_fall = ~cmd_s & cmd_p;
  assign s2_fall  = ~s2_s & s2_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend     <= 1'b0;
      rdy      <= 1'b0;
      cpu_irq  <= 1'b0;
      q_resp   <= 1'b0;
      rd_valid <= 1'b0;
      rd_en    <= 1'b0;
      cmd_busy <= 1'b0;
      miss_cnt <= '0;
    end else begin
      if (miss_cnt != '0) begin
        miss_cnt <= miss_cnt - CW'(1);
        if (miss_cnt == CW'(1)) rdy <= 1'b0;
      end
      if (cmd_rise) begin
        if (pend) cmd_busy <= 1'b1;
        else begin
          pend <= 1'b1;
          if (!rd_s) q_resp <= 1'b1;
          else if (rdy && mt_s) begin
            q_resp   <= 1'b1;
            rd_valid <= 1'b1;
            rd_en    <= 1'b1;
          end else if (rdy) miss_cnt <= CW'(MISS_DLY);
        end
      end
      if (cmd_fall) begin
        q_resp   <= 1'b0;
        rd_valid <= 1'b0;
        rd_en    <= 1'b0;
        cmd_busy <= 1'b0;
        if (rd_valid) rdy <= 1'b0;
      end
      if (s2_fall && pend) cpu_irq <= 1'b1;
      if (cpu_wde) begin
        pend    <= 1'b0;
        cpu_irq <= 1'b0;
      end
      if (cpu_latch) rdy <= 1'b1;
    end

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && !cpu_wde |=> cpu_irq);

  // R4
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wde |=> !cpu_irq);

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(s2_p && !s2_s));

  // R6
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (q_resp && rd_en));

  // R5
  busy_noq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> !q_resp);
endmodule

// File: tb/sim_bus_cmd_sync.sv
module sim_bus_cmd_sync;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_stb = 0, rd_sel = 0, cmd_match = 0, s2_stb = 0, cpu_wde = 0, cpu_latch = 0;
  logic q_resp, rd_valid, rd_en, cpu_irq, cmd_busy;
  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  bus_cmd_sync u0 (.clk, .rst_n, .cmd_stb, .rd_sel, .cmd_match, .s2_stb,
    .cpu_wde, .cpu_latch, .q_resp, .rd_valid, .rd_en, .cpu_irq, .cmd_busy);

  // {op[1:0], rd, match, exp_q, exp_rv, exp_busy, exp_irq}; op 0=command 1=cpu clear 2=cpu latch
  localparam logic [7:0] VEC [15] = '{
    8'b00_0_0_1_0_0_1, 8'b00_0_0_0_0_1_1, 8'b01_0_0_0_0_0_0,
    8'b00_1_1_0_0_0_1, 8'b10_0_0_0_0_0_1, 8'b01_0_0_0_0_0_0,
    8'b00_1_1_1_1_0_1, 8'b01_0_0_0_0_0_0, 8'b00_1_1_0_0_0_1,
    8'b10_0_0_0_0_0_1, 8'b01_0_0_0_0_0_0, 8'b00_1_0_0_0_0_1,
    8'b01_0_0_0_0_0_0, 8'b00_1_1_0_0_0_1, 8'b01_0_0_0_0_0_0};
  string vtag [15];

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_cmd(input logic rd, input logic mt, input logic eq, input logic ev,
                         input logic eb, input logic ei, input string tag);
    rd_sel = rd; cmd_match = mt; cmd_stb = 1'b1;
    wait_n(5);
    chk(tag, "q_resp", q_resp, eq);
    chk(tag, "rd_valid", rd_valid, ev);
    chk(tag, "rd_en", rd_en, ev);
    chk(tag, "cmd_busy", cmd_busy, eb);
    s2_stb = 1'b1; wait_n(3); s2_stb = 1'b0; wait_n(5);
    chk(tag, "cpu_irq", cpu_irq, ei);
    cmd_stb = 1'b0; wait_n(5);
  endtask

  task automatic cpu_pulse(input logic clr, input logic ei, input string tag);
    if (clr) cpu_wde = 1'b1; else cpu_latch = 1'b1;
    @(negedge clk);
    cpu_wde = 1'b0; cpu_latch = 1'b0;
    @(negedge clk);
    chk(tag, "cpu_irq", cpu_irq, ei);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 50000) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vtag = '{"R2", "R5", "R4", "R7", "R9", "R4", "R6", "R4", "R6", "R9", "R4", "R8", "R4", "R8", "R4"};
    wait_n(3);
    // R1 reset state
    chk("R1", "q_resp", q_resp, 1'b0);
    chk("R1", "rd_valid", rd_valid, 1'b0);
    chk("R1", "rd_en", rd_en, 1'b0);
    chk("R1", "cpu_irq", cpu_irq, 1'b0);
    chk("R1", "cmd_busy", cmd_busy, 1'b0);
    rst_n = 1'b1;
    wait_n(3);

    for (int k = 0; k < 15; k++) begin
      if (VEC[k][7:6] == 2'd0)
        bus_cmd(VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0], vtag[k]);
      else
        cpu_pulse(VEC[k][7:6] == 2'd1, VEC[k][0], vtag[k]);
    end

    // R3: accepted command, no interrupt until S2 falls
    cmd_stb = 1'b1; rd_sel = 1'b0;
    wait_n(5);
    s2_stb = 1'b1; wait_n(5);
    chk("R3", "cpu_irq before S2 falls", cpu_irq, 1'b0);
    s2_stb = 1'b0; wait_n(5);
    chk("R3", "cpu_irq after S2 falls", cpu_irq, 1'b1);
    cmd_stb = 1'b0;
    // R4: interrupt holds without a clear
    wait_n(40);
    chk("R4", "cpu_irq held", cpu_irq, 1'b1);
    cpu_pulse(1'b1, 1'b0, "R4");

    // R8: short mismatched read, then a matching read after the discard delay
    cpu_pulse(1'b0, 1'b0, "R9");
    rd_sel = 1'b1; cmd_match = 1'b0; cmd_stb = 1'b1;
    wait_n(5);
    chk("R8", "q_resp on mismatch", q_resp, 1'b0);
    cmd_stb = 1'b0; wait_n(15);
    cpu_pulse(1'b1, 1'b0, "R4");
    bus_cmd(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    cpu_pulse(1'b1, 1'b0, "R4");

    // R1: reset while pending
    bus_cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    rst_n = 1'b0; wait_n(2);
    chk("R1", "cpu_irq after reset", cpu_irq, 1'b0);
    rst_n = 1'b1; wait_n(3);
    bus_cmd(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule